// File: doc/BRIEF.md
# Receive Character Queue with Threshold Flow Control

This block sits between a serial receiver and a host register interface. It stores incoming 8-bit characters in a first-in first-out queue, 64 deep by default. It reports how many characters are waiting and raises an interrupt-trigger flag once the fill reaches a programmable level. It also drives an active-low request-to-send line. That line tells the far end to pause when the queue gets close to full, and lets it resume once the host has drained the queue far enough.

The request-to-send line is controlled by a two-state machine with a hysteresis gap. In state FLOW_OPEN the line is low, and the machine takes transition OPEN_TO_HALTED once the fill is at or above the halt threshold. In state FLOW_HALTED the line is high, and the machine takes transition HALTED_TO_OPEN once the fill is at or below the resume threshold. Both thresholds are 4-bit fields counted in units of four characters. A third transition, FORCE_OPEN, returns the machine to FLOW_OPEN whenever flow control is disabled.

The interrupt level comes from a fine 4-bit field, also in units of four characters. When that field is zero, a coarse 2-bit selector picks the level instead.

Top module: `rx_fifo_flow`

## Requirements
- R1: After reset, fill_lvl is 0, data_ready is 0, overrun is 0 and rts_n is 0.
- R2: Characters leave in the order they were written. rd_data always shows the oldest stored character, and up to 64 characters are held.
- R3: fill_lvl changes in the cycle after a strobe: +1 for an accepted write, -1 for a read of a non-empty queue. A read of an empty queue has no effect.
- R4: data_ready is 1 exactly when fill_lvl is at least 1.
- R5: A write to a full queue, with no read in the same cycle, is dropped and sets the sticky overrun flag. stat_rd clears overrun. If a dropped write and stat_rd occur in the same cycle, overrun stays set.
- R6: A read and a write in the same cycle on a full queue both take effect. fill_lvl stays at 64 and overrun is not set.
- R7: fifo_clr empties the queue by the next cycle. It takes priority over rd_en and wr_en in the same cycle.
- R8: When fine_lvl is nonzero, rx_trig is 1 exactly when fill_lvl >= 4*fine_lvl.
- R9: When fine_lvl is 0, the rx_trig level is chosen by coarse_sel: 0 selects 8, 1 selects 16, 2 selects 56 and 3 selects 60.
- R10: flow_lvls[3:0] is the halt field and flow_lvls[7:4] is the resume field. With flow_en=1, rts_n rises one cycle after fill_lvl >= 4*halt.
- R11: With flow_en=1 and rts_n high, rts_n falls one cycle after fill_lvl <= 4*resume.
- R12: With flow_en=0, rts_n is low from the next cycle on, whatever the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe from the receiver |
| wr_data | input | 8 | Character to store |
| rd_en | input | 1 | Read strobe from the host; pops the oldest character |
| rd_data | output | 8 | Oldest stored character (show-ahead) |
| fifo_clr | input | 1 | Queue reset pulse |
| stat_rd | input | 1 | Status read strobe; clears overrun |
| flow_en | input | 1 | Enables automatic request-to-send |
| flow_lvls | input | 8 | Resume level in [7:4], halt level in [3:0], units of 4 |
| coarse_sel | input | 2 | Coarse interrupt level select |
| fine_lvl | input | 4 | Fine interrupt level, units of 4; 0 selects coarse |
| data_ready | output | 1 | At least one character waiting |
| fill_lvl | output | 7 | Number of characters stored |
| overrun | output | 1 | Sticky dropped-write flag |
| rx_trig | output | 1 | Fill has reached the interrupt level |
| rts_n | output | 1 | Active-low request to send |

## Verification
The bench builds the block with its default parameters: 64 entries, 8-bit characters and a step of 4. With these values every fine level, every coarse selection and every legal halt/resume pair can be swept across the full 0-to-64 fill range within the cycle budget. Each interrupt configuration is checked at every fill value. Each of the 120 threshold pairs is driven up through the halt point and back down through the resume point, so both ends of the hysteresis gap are reached at their exact boundary.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic {
        FLOW_OPEN   = 1'b0,
        FLOW_HALTED = 1'b1
    } flow_st_t;

    // Coarse interrupt levels, scaled to the queue depth at the top end
    function automatic int coarse_level(input logic [1:0] sel, input int depth);
        case (sel)
            2'd0:    return 8;
            2'd1:    return 16;
            2'd2:    return depth - 8;
            default: return depth - 4;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push && !clr) begin
            mem[wptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= bump(wptr);
            if (pop)  rptr <= bump(rptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign dout = mem[rptr];

endmodule

// File: rtl/rxq_trig.sv
module rxq_trig #(
    parameter int DEPTH = 64,
    parameter int STEP  = 4,
    parameter int LVLW  = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0]   count,
    input  logic [LVLW-1:0] fine,
    input  logic [1:0]      coarse_sel,
    output logic            trig
);
    int level;

    always_comb begin
        if (fine != '0) begin
            level = int'(fine) * STEP;
        end else begin
            level = rxq_pkg::coarse_level(coarse_sel, DEPTH);
        end
        trig = int'(count) >= level;
    end

endmodule

// File: rtl/rxq_flow.sv
module rxq_flow #(
    parameter int DEPTH = 64,
    parameter int STEP  = 4,
    parameter int LVLW  = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [CW-1:0]   count,
    input  logic [LVLW-1:0] halt_lvl,
    input  logic [LVLW-1:0] resume_lvl,
    output logic            rts_n
);
    import rxq_pkg::*;

    flow_st_t state, state_nxt;
    int halt_chars, resume_chars;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FLOW_OPEN;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        halt_chars   = int'(halt_lvl) * STEP;
        resume_chars = int'(resume_lvl) * STEP;
        state_nxt    = state;
        if (!en) begin
            state_nxt = FLOW_OPEN;                               // FORCE_OPEN
        end else begin
            unique case (state)
                FLOW_OPEN:   if (int'(count) >= halt_chars)
                                 state_nxt = FLOW_HALTED;        // OPEN_TO_HALTED
                FLOW_HALTED: if (int'(count) <= resume_chars)
                                 state_nxt = FLOW_OPEN;          // HALTED_TO_OPEN
                default:     state_nxt = FLOW_OPEN;
            endcase
        end
    end

    always_comb begin
        rts_n = (state == FLOW_HALTED);
    end

endmodule

// File: rtl/rx_fifo_flow.sv
module rx_fifo_flow #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    parameter int STEP  = 4,
    parameter int LVLW  = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [DW-1:0]   wr_data,
    input  logic            rd_en,
    output logic [DW-1:0]   rd_data,
    input  logic            fifo_clr,
    input  logic            stat_rd,
    input  logic            flow_en,
    input  logic [2*LVLW-1:0] flow_lvls,
    input  logic [1:0]      coarse_sel,
    input  logic [LVLW-1:0] fine_lvl,
    output logic            data_ready,
    output logic [CW-1:0]   fill_lvl,
    output logic            overrun,
    output logic            rx_trig,
    output logic            rts_n
);
    logic push, pop, full, dropped;

    assign full    = (fill_lvl == CW'(DEPTH));
    assign pop     = rd_en && (fill_lvl != '0);
    assign push    = wr_en && (!full || pop);
    assign dropped = wr_en && !push && !fifo_clr;

    rxq_store #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fifo_clr),
        .push  (push),
        .pop   (pop),
        .din   (wr_data),
        .dout  (rd_data),
        .count (fill_lvl)
    );

    rxq_trig #(.DEPTH(DEPTH), .STEP(STEP), .LVLW(LVLW), .CW(CW)) u_trig (
        .count      (fill_lvl),
        .fine       (fine_lvl),
        .coarse_sel (coarse_sel),
        .trig       (rx_trig)
    );

    rxq_flow #(.DEPTH(DEPTH), .STEP(STEP), .LVLW(LVLW), .CW(CW)) u_flow (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (flow_en),
        .count      (fill_lvl),
        .halt_lvl   (flow_lvls[LVLW-1:0]),
        .resume_lvl (flow_lvls[2*LVLW-1:LVLW]),
        .rts_n      (rts_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (dropped) begin
            overrun <= 1'b1;
        end else if (stat_rd) begin
            overrun <= 1'b0;
        end
    end

    assign data_ready = (fill_lvl != '0);

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int DEPTH = 64,
    parameter int STEP  = 4,
    parameter int LVLW  = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic            rd_en,
    input logic            fifo_clr,
    input logic            flow_en,
    input logic [2*LVLW-1:0] flow_lvls,
    input logic [CW-1:0]   fill_lvl,
    input logic            overrun,
    input logic            rts_n
);
    // R2: never more than DEPTH characters
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fill_lvl) <= DEPTH);

    // R3: fill moves by at most one per cycle outside a clear
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fifo_clr) |->
            (int'(fill_lvl) == int'($past(fill_lvl)) ||
             int'(fill_lvl) == int'($past(fill_lvl)) + 1 ||
             int'(fill_lvl) + 1 == int'($past(fill_lvl))));

    // R5: write into a full queue without a read is dropped and flagged
    a_r5_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fill_lvl) == DEPTH && wr_en && !rd_en && !fifo_clr) |=>
            (int'(fill_lvl) == DEPTH && overrun));

    // R7: clear empties the queue
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (fill_lvl == '0));

    // R10: rts_n only rises after the fill reached the halt level
    a_r10_halt_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rts_n) |->
            int'($past(fill_lvl)) >= int'($past(flow_lvls[LVLW-1:0])) * STEP);

    // R11: rts_n only falls at or below the resume level while enabled
    a_r11_resume_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rts_n) && $past(flow_en)) |->
            int'($past(fill_lvl)) <= int'($past(flow_lvls[2*LVLW-1:LVLW])) * STEP);

    // R12: disabled flow control releases the line
    a_r12_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !flow_en |=> !rts_n);

endmodule

bind rx_fifo_flow rxq_chk #(.DEPTH(DEPTH), .STEP(STEP), .LVLW(LVLW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .fifo_clr  (fifo_clr),
    .flow_en   (flow_en),
    .flow_lvls (flow_lvls),
    .fill_lvl  (fill_lvl),
    .overrun   (overrun),
    .rts_n     (rts_n)
);

// File: tb/rx_fifo_flow_bench.sv
`timescale 1ns/1ps
module rx_fifo_flow_bench;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, fifo_clr = 1'b0, stat_rd = 1'b0;
    logic       flow_en = 1'b0;
    logic [7:0] wr_data = '0, flow_lvls = '0;
    logic [1:0] coarse_sel = '0;
    logic [3:0] fine_lvl = '0;
    logic [7:0] rd_data;
    logic       data_ready, overrun, rx_trig, rts_n;
    logic [6:0] fill_lvl;

    int tests = 0, fails = 0;
    bit done = 0;
    logic [7:0] q[$];
    bit m_halt = 0;
    logic [7:0] seed = 8'h5a;

    always #2 clk = ~clk;

    rx_fifo_flow u_rx_fifo_flow (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .fifo_clr(fifo_clr), .stat_rd(stat_rd),
        .flow_en(flow_en), .flow_lvls(flow_lvls), .coarse_sel(coarse_sel),
        .fine_lvl(fine_lvl), .data_ready(data_ready), .fill_lvl(fill_lvl),
        .overrun(overrun), .rx_trig(rx_trig), .rts_n(rts_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_fill();
        chk("R3 fill", int'(fill_lvl), q.size());
        chk("R4 ready", int'(data_ready), int'(q.size() != 0));
    endtask

    task automatic do_wr();
        seed = seed * 8'd37 + 8'd11;
        wr_data = seed;
        wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
        if (q.size() < DEPTH) q.push_back(seed);
    endtask

    task automatic do_rd();
        if (q.size() != 0) chk("R2 order", int'(rd_data), int'(q[0]));
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        if (q.size() != 0) void'(q.pop_front());
    endtask

    task automatic do_clr();
        fifo_clr = 1'b1;
        tick();
        fifo_clr = 1'b0;
        q.delete();
    endtask

    task automatic rts_model();
        int h = int'(flow_lvls[3:0]) * 4;
        int r = int'(flow_lvls[7:4]) * 4;
        if (!flow_en) m_halt = 0;
        else if (m_halt) begin if (q.size() <= r) m_halt = 0; end
        else if (q.size() >= h) m_halt = 1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 fill", int'(fill_lvl), 0);
        chk("R1 ready", int'(data_ready), 0);
        chk("R1 overrun", int'(overrun), 0);
        chk("R1 rts_n", int'(rts_n), 0);

        // R3 read of empty ignored
        do_rd(); chk_fill();

        // R2/R3/R4 fill to full then R5 overflow
        for (int i = 0; i < DEPTH; i++) begin do_wr(); chk_fill(); end
        chk("R5 no overrun yet", int'(overrun), 0);
        do_wr(); chk_fill();
        chk("R5 overrun set", int'(overrun), 1);
        tick();
        chk("R5 overrun sticky", int'(overrun), 1);
        // R5 dropped write and stat_rd together: set wins
        wr_en = 1'b1; stat_rd = 1'b1; tick(); wr_en = 1'b0; stat_rd = 1'b0;
        chk("R5 set wins", int'(overrun), 1);
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
        chk("R5 cleared", int'(overrun), 0);

        // R6 simultaneous read and write when full
        chk("R6 head", int'(rd_data), int'(q[0]));
        seed = seed + 8'd1;
        wr_data = seed; wr_en = 1'b1; rd_en = 1'b1; tick();
        wr_en = 1'b0; rd_en = 1'b0;
        void'(q.pop_front()); q.push_back(seed);
        chk("R6 fill", int'(fill_lvl), DEPTH);
        chk("R6 overrun", int'(overrun), 0);

        // R2 drain all in order
        while (q.size() != 0) begin do_rd(); chk_fill(); end

        // R7 clear, with priority over strobes
        for (int i = 0; i < 5; i++) do_wr();
        wr_en = 1'b1; rd_en = 1'b1; fifo_clr = 1'b1; tick();
        wr_en = 1'b0; rd_en = 1'b0; fifo_clr = 1'b0; q.delete();
        chk("R7 clear fill", int'(fill_lvl), 0);
        chk("R7 clear ready", int'(data_ready), 0);
        do_wr(); do_wr(); do_rd(); do_rd(); chk_fill();

        // R8/R9 interrupt level sweep
        for (int cfg = 0; cfg < 19; cfg++) begin
            int lvl;
            coarse_sel = 2'(cfg % 4);
            fine_lvl = (cfg < 4) ? 4'd0 : 4'(cfg - 3);
            if (fine_lvl != 0) lvl = int'(fine_lvl) * 4;
            else case (coarse_sel)
                2'd0: lvl = 8; 2'd1: lvl = 16; 2'd2: lvl = 56; default: lvl = 60;
            endcase
            do_clr();
            chk(fine_lvl != 0 ? "R8 trig" : "R9 trig", int'(rx_trig), int'(0 >= lvl));
            for (int n = 1; n <= DEPTH; n++) begin
                do_wr();
                chk(fine_lvl != 0 ? "R8 trig" : "R9 trig", int'(rx_trig), int'(n >= lvl));
            end
        end

        // R10/R11 hysteresis sweep over all legal pairs
        flow_en = 1'b1;
        for (int h = 1; h < 16; h++) begin
            for (int r = 0; r < h; r++) begin
                int top = (h * 4 + 2 > DEPTH) ? DEPTH : h * 4 + 2;
                flow_lvls = {4'(r), 4'(h)};
                do_clr(); tick(); m_halt = 0;
                chk("R11 open after clear", int'(rts_n), 0);
                while (q.size() < top) begin
                    do_wr(); tick(); rts_model();
                    chk("R10 halt", int'(rts_n), int'(m_halt));
                end
                while (q.size() != 0) begin
                    do_rd(); tick(); rts_model();
                    chk("R11 resume", int'(rts_n), int'(m_halt));
                end
            end
        end

        // R12 disable while halted, then fill with flow disabled
        flow_lvls = {4'd0, 4'd1};
        do_clr();
        for (int i = 0; i < 8; i++) do_wr();
        tick();
        chk("R10 halted before disable", int'(rts_n), 1);
        flow_en = 1'b0; tick();
        chk("R12 released", int'(rts_n), 0);
        while (q.size() < DEPTH) do_wr();
        tick();
        chk("R12 stays low full", int'(rts_n), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule